// File: doc/BRIEF.md
# DRAM Bank Activation Timing Tracker

This block sits between a DDR SDRAM controller's scheduler and its command pins. It keeps, for each of four banks, whether a row is open and which row it is. Each clock it takes at most one request (open a row, read, write or close a bank) and decides whether that request may be issued now. A granted request appears one clock later on registered, active-low command pins. A refused request produces an idle (no-operation) encoding.

Three minimum intervals are enforced:
- open-to-column delay per bank;
- open-to-open interval within one bank;
- open-to-open interval across any two banks.

Each interval is a parameter in nanoseconds. At elaboration it is turned into a whole clock count by dividing by the clock period and rounding up. A read or write to an open bank whose stored row differs from the requested row is refused and flagged as a row miss, so the scheduler can close the bank first.

Top module: `bank_act_tracker`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, every bank reads closed, `grant` and `row_miss` are 0, and the pins show NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1).
- R2: A granted open-row request (`req_cmd`=0) drives `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=1 with `cmd_bank`/`cmd_addr` equal to the request. From that same output cycle, the bank reads open and holds the row.
- R3: A read (`req_cmd`=1) or write (`req_cmd`=2) to a closed bank is never granted.
- R4: After an open-row command is decided at edge E, a read or write to that bank is refused at edges before E+RCD and may be granted from E+RCD on.
- R5: An open-row request to a bank that is already open is refused.
- R6: Two open-row commands to the same bank are at least RC edges apart.
- R7: Two open-row commands to any banks are at least RRD edges apart.
- R8: A close request (`req_cmd`=3) is always granted, drives `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, and marks the bank closed.
- R9: A read or write to an open bank whose stored row differs from `req_row` is refused, raises `row_miss` for one output cycle, and leaves bank state unchanged.
- R10: A granted read drives pins 0,1,0,1 and a granted write drives 0,1,0,0 (`cs_n`,`ras_n`,`cas_n`,`we_n`). An idle or refused cycle drives NOP.
- R11: Each clock count is ceil(ns*1000 / TCK_PS). With the defaults (7500 ps; 20, 60, 15 ns) this gives RCD=3, RC=8 and RRD=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_cmd | input | 2 | 0 open row, 1 read, 2 write, 3 close bank |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row address |
| grant | output | 1 | Request of the previous cycle was issued |
| row_miss | output | 1 | Previous read/write hit an open bank with another row |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cmd_bank | output | 2 | Bank of the issued command |
| cmd_addr | output | 13 | Row of the issued command, 0 when idle |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Stored row per bank, bank b at bits [13b+12:13b] |

## Verification
The assertions assume a well-formed request stream: `req_cmd` and `req_bank` are stable while `req_valid` is high within a cycle, and the scheduler never counts on a refused request being remembered. They also assume no other agent drives the pins between grants. The stimulus keeps to this in two ways:
- It re-presents a request refused only for timing (R4, R6, R7) unchanged until it is granted.
- It drops, after one cycle, a request that can never succeed (closed bank or row miss).

The stimulus draws rows from a small set so that both hits and misses occur often.

// File: rtl/bat_pkg.sv
package bat_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } bat_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } bat_pins_t;

  localparam bat_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  // ceiling division of a nanosecond limit by a picosecond period, at least one clock
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned ps);
    int unsigned q;
    q = (ns * 1000 + ps - 1) / ps;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic bat_pins_t encode(input bat_cmd_e c);
    bat_pins_t p;
    case (c)
      CMD_ACT: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
      CMD_RD:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
      CMD_WR:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/bat_interval.sv
module bat_interval #(
  parameter int unsigned CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic ready
);
  localparam int unsigned LOADV = (CYCLES > 0) ? CYCLES - 1 : 0;
  localparam int unsigned W     = (LOADV < 2) ? 1 : $clog2(LOADV + 1);
  localparam logic [W-1:0] LOADW = LOADV[W-1:0];

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= LOADW;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOADW);                                                  // R11
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));      // R4

endmodule

// File: rtl/bat_bank.sv
module bat_bank #(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned RCD_CK = 3,
  parameter int unsigned RC_CK  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_out,
  output logic             rcd_ok,
  output logic             rc_ok
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_go) begin
      open_q <= 1'b1;
      row_q  <= row_in;
    end else if (pre_go) begin
      open_q <= 1'b0;
    end
  end

  bat_interval #(.CYCLES(RCD_CK)) u_rcd (.clk(clk), .rst(rst), .load(act_go), .ready(rcd_ok));
  bat_interval #(.CYCLES(RC_CK))  u_rc  (.clk(clk), .rst(rst), .load(act_go), .ready(rc_ok));

  assign is_open = open_q;
  assign row_out = row_q;

  AST_NO_ACT_OPEN: assert property (@(posedge clk) disable iff (rst)
    act_go |-> !open_q);                                              // R5
  AST_RC_RESPECT: assert property (@(posedge clk) disable iff (rst)
    act_go |-> rc_ok);                                                // R6
  AST_GO_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(act_go && pre_go));                                             // R8

endmodule

// File: rtl/bank_act_tracker.sv
module bank_act_tracker #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned TCK_PS    = 7500,
  parameter int unsigned TRCD_NS   = 20,
  parameter int unsigned TRC_NS    = 60,
  parameter int unsigned TRRD_NS   = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [1:0]                 req_cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]           req_row,
  output logic                       grant,
  output logic                       row_miss,
  output logic                       cs_n,
  output logic                       ras_n,
  output logic                       cas_n,
  output logic                       we_n,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic [ROW_W-1:0]           cmd_addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows
);
  import bat_pkg::*;

  localparam int unsigned BA_W   = $clog2(NUM_BANKS);
  localparam int unsigned RCD_CK = ns_to_clk(TRCD_NS, TCK_PS);
  localparam int unsigned RC_CK  = ns_to_clk(TRC_NS, TCK_PS);
  localparam int unsigned RRD_CK = ns_to_clk(TRRD_NS, TCK_PS);

  logic [NUM_BANKS-1:0] open_w, rcd_ok_w, rc_ok_w, act_go, pre_go;
  logic [ROW_W-1:0]     row_w [NUM_BANKS];
  logic                 rrd_ok;

  bat_cmd_e  cmd;
  logic      dec_grant, dec_miss, row_hit, any_act;
  bat_pins_t pins_q;

  assign cmd = bat_cmd_e'(req_cmd);

  always_comb begin
    dec_grant = 1'b0;
    dec_miss  = 1'b0;
    row_hit   = open_w[req_bank] && (row_w[req_bank] == req_row);
    if (req_valid) begin
      case (cmd)
        CMD_ACT: dec_grant = !open_w[req_bank] && rc_ok_w[req_bank] && rrd_ok;
        CMD_RD, CMD_WR: begin
          dec_grant = row_hit && rcd_ok_w[req_bank];
          dec_miss  = open_w[req_bank] && !row_hit;
        end
        default: dec_grant = 1'b1;
      endcase
    end
  end

  assign any_act = dec_grant && (cmd == CMD_ACT);

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign act_go[b] = any_act && (req_bank == BA_W'(b));
      assign pre_go[b] = dec_grant && (cmd == CMD_PRE) && (req_bank == BA_W'(b));
      bat_bank #(.ROW_W(ROW_W), .RCD_CK(RCD_CK), .RC_CK(RC_CK)) u_bank (
        .clk(clk), .rst(rst), .act_go(act_go[b]), .pre_go(pre_go[b]),
        .row_in(req_row), .is_open(open_w[b]), .row_out(row_w[b]),
        .rcd_ok(rcd_ok_w[b]), .rc_ok(rc_ok_w[b]));
      assign open_rows[b*ROW_W +: ROW_W] = row_w[b];
    end
  endgenerate

  bat_interval #(.CYCLES(RRD_CK)) u_rrd (.clk(clk), .rst(rst), .load(any_act), .ready(rrd_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= 1'b0;
      row_miss <= 1'b0;
      pins_q   <= PINS_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
    end else begin
      grant    <= dec_grant;
      row_miss <= dec_miss;
      pins_q   <= dec_grant ? encode(cmd) : PINS_NOP;
      cmd_bank <= dec_grant ? req_bank : '0;
      cmd_addr <= dec_grant ? req_row : '0;
    end
  end

  assign cs_n      = pins_q.cs_n;
  assign ras_n     = pins_q.ras_n;
  assign cas_n     = pins_q.cas_n;
  assign we_n      = pins_q.we_n;
  assign bank_open = open_w;

  // gap since the last issued open-row command, saturating at RRD_CK
  localparam int unsigned GW = $clog2(RRD_CK + 1);
  logic [GW-1:0] gap_q;
  logic          act_vis;
  assign act_vis = grant && !ras_n && we_n;

  always_ff @(posedge clk) begin
    if (rst)                         gap_q <= GW'(RRD_CK);
    else if (act_vis)                gap_q <= GW'(1);
    else if (gap_q < GW'(RRD_CK))    gap_q <= gap_q + 1'b1;
  end

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    !grant |-> (!cs_n && ras_n && cas_n && we_n));                     // R10
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    act_vis |-> (bank_open[cmd_bank] && open_rows[cmd_bank*ROW_W +: ROW_W] == cmd_addr)); // R2
  AST_RW_HIT: assert property (@(posedge clk) disable iff (rst)
    (grant && !cas_n) |-> (bank_open[cmd_bank] && open_rows[cmd_bank*ROW_W +: ROW_W] == cmd_addr)); // R3
  AST_MISS_REFUSED: assert property (@(posedge clk) disable iff (rst)
    row_miss |-> !grant);                                             // R9
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (grant && !ras_n && !we_n) |-> !bank_open[cmd_bank]);             // R8
  AST_RRD_GAP: assert property (@(posedge clk) disable iff (rst)
    act_vis |-> (gap_q >= GW'(RRD_CK)));                              // R7

endmodule

// File: tb/bank_act_tracker_tb.sv
module bank_act_tracker_tb_top;
  localparam int TCK = 7500;
  localparam int RCD = (20 * 1000 + TCK - 1) / TCK;
  localparam int RC  = (60 * 1000 + TCK - 1) / TCK;
  localparam int RRD = (15 * 1000 + TCK - 1) / TCK;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_cmd = 0, req_bank = 0;
  logic [12:0] req_row = 0;
  logic grant, row_miss, cs_n, ras_n, cas_n, we_n;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_addr;
  logic [3:0] bank_open;
  logic [51:0] open_rows;

  bank_act_tracker dut_i (.clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_row(req_row), .grant(grant), .row_miss(row_miss), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .bank_open(bank_open), .open_rows(open_rows));

  always #5 clk = ~clk;

  int total = 0, bad = 0, edge_no = 0;
  always @(posedge clk) edge_no <= edge_no + 1;

  bit        mopen [4];
  logic [12:0] mrow [4];
  int        last_act [4];
  int        last_any;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pins_of(input logic [1:0] c);
    case (c)
      2'd0: return 4'b0011;
      2'd1: return 4'b0101;
      2'd2: return 4'b0100;
      default: return 4'b0010;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin mopen[i] = 0; mrow[i] = 0; last_act[i] = -1000; end
    last_any = -1000;
  endtask

  // expected decision at edge e; tag names the rule that decided it
  task automatic expect_dec(input bit v, input logic [1:0] c, input logic [1:0] b,
                            input logic [12:0] r, input int e,
                            output bit g, output bit m, output string tag);
    g = 0; m = 0; tag = "R10";
    if (!v) return;
    case (c)
      2'd0: begin
        if (mopen[b])                    tag = "R5";
        else if (e - last_act[b] < RC)   tag = "R6";
        else if (e - last_any < RRD)     tag = "R7";
        else begin g = 1; tag = "R2"; end
      end
      2'd1, 2'd2: begin
        if (!mopen[b])                   tag = "R3";
        else if (mrow[b] != r) begin m = 1; tag = "R9"; end
        else if (e - last_act[b] < RCD)  tag = "R4";
        else begin g = 1; tag = "R10"; end
      end
      default: begin g = 1; tag = "R8"; end
    endcase
  endtask

  task automatic step(input bit v, input logic [1:0] c, input logic [1:0] b,
                      input logic [12:0] r, output bit g, output string tag);
    bit m;
    int e;
    e = edge_no + 1;
    expect_dec(v, c, b, r, e, g, m, tag);
    req_valid = v; req_cmd = c; req_bank = b; req_row = r;
    @(posedge clk); @(negedge clk);
    chk(grant == g, tag, grant, g);
    chk(row_miss == m, "R9", row_miss, m);
    chk({cs_n, ras_n, cas_n, we_n} == (g ? pins_of(c) : 4'b0111), g ? tag : "R10",
        {cs_n, ras_n, cas_n, we_n}, g ? pins_of(c) : 4'b0111);
    if (g) begin
      chk(cmd_bank == b && cmd_addr == r, tag, {cmd_bank, cmd_addr}, {b, r});
      if (c == 2'd0) begin
        mopen[b] = 1; mrow[b] = r; last_act[b] = e; last_any = e;
      end else if (c == 2'd3) mopen[b] = 0;
    end
    chk(bank_open[b] == mopen[b], tag, bank_open[b], mopen[b]);
    if (mopen[b]) chk(open_rows[b*13 +: 13] == mrow[b], tag, open_rows[b*13 +: 13], mrow[b]);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit g;
    string t;
    bit held;
    logic [1:0] hc, hb;
    logic [12:0] hr;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bank_open == 4'b0 && !grant && !row_miss, "R1", {bank_open, grant, row_miss}, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    rst = 0;

    // R11: derived counts and the exact row-to-column edge
    chk(RCD == 3 && RC == 8 && RRD == 2, "R11", RCD, 3);
    step(1, 2'd0, 2'd0, 13'd5, g, t);
    chk(g, "R2", g, 1);
    step(1, 2'd0, 2'd1, 13'd9, g, t);        // one edge later: different-bank interval
    chk(!g, "R7", g, 0);
    step(1, 2'd1, 2'd0, 13'd5, g, t);        // edge +2
    chk(!g, "R11", g, 0);
    step(1, 2'd1, 2'd0, 13'd5, g, t);        // edge +3 = RCD
    chk(g, "R11", g, 1);
    step(1, 2'd2, 2'd0, 13'd6, g, t);        // wrong row
    chk(!g, "R9", g, 0);
    step(1, 2'd0, 2'd0, 13'd7, g, t);        // bank already open
    chk(!g, "R5", g, 0);
    step(1, 2'd3, 2'd0, 13'd0, g, t);
    chk(g && bank_open[0] == 0, "R8", bank_open[0], 0);
    step(1, 2'd0, 2'd0, 13'd7, g, t);        // edge +7 < RC
    chk(!g, "R6", g, 0);
    step(1, 2'd0, 2'd0, 13'd7, g, t);        // edge +8 = RC
    chk(g, "R6", g, 1);
    step(1, 2'd1, 2'd2, 13'd1, g, t);        // closed bank read
    chk(!g, "R3", g, 0);

    // random phase
    held = 0;
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] c, b;
      logic [12:0] r;
      bit v;
      if (held) begin v = 1; c = hc; b = hb; r = hr; end
      else begin
        v = ($urandom % 5) != 0;
        c = 2'($urandom % 4);
        b = 2'($urandom % 4);
        r = 13'($urandom % 3);
      end
      step(v, c, b, r, g, t);
      held = v && !g && (t == "R4" || t == "R6" || t == "R7");
      hc = c; hb = b; hr = r;
    end
    step(0, 2'd0, 2'd0, 13'd0, g, t);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule